// File: doc/BRIEF.md
# Clock Source Select and Gate Register Unit

This block holds the control state for one clock multiplexer: which parent clock is selected and whether the output clock is gated off. Software reaches it through a small 32-bit register bus. The block drives a registered select index and a clock-enable level toward a separate switching circuit. It does not switch clocks itself.

Software can change the select in two ways. The first is a read-modify-write control word, in which the select field sits at a parameterised shift and the remaining bits are kept as stored. The second uses separate clear and set registers that edit a staged copy of the select. When the update bit is configured, the staged copy becomes active only when software writes a one to the update bit of a separate update register. Without the update bit, a set write commits the staged copy directly.

A committed index at or above the parent count is refused. The previous select stays in force and a sticky error flag rises.

Top module: `cmux_sel_regs`

## Requirements
- R1: After reset the select output is 0, the clock enable is 0 (gate bit set, clock off), and the error and pending flags are 0.
- R2: A write to the control word (byte offset 0x00) moves its select field (bits SEL_SHIFT+SEL_W-1:SEL_SHIFT, default 6:4) to the select output on the next cycle. Its gate bit (bit GATE_BIT, default 8, 1 = clock off) is taken directly. All other bits are stored and read back unchanged.
- R3: A select value at or above NUM_PARENTS (default 5) is refused on any commit path. The output keeps its previous index and the error flag is set. Only reset clears the error flag.
- R4: A write to the clear register (0x04 + 4 = 0x08) clears the staged select bits where its select field holds ones. It does not change the select output.
- R5: With the update bit configured, a write to the set register (0x04) ORs its select field into the staged copy, leaves the select output unchanged, and raises the pending flag.
- R6: A write to the update register (0x0C) with bit UPD_BIT (default 0) at 1 commits the staged copy on the next cycle and clears the pending flag. A write with that bit at 0 has no effect.
- R7: Without the update bit (HAS_UPD = 0), a set write commits the result of the OR on the next cycle and leaves the pending flag clear.
- R8: A clear-register write with the gate bit at 1 enables the clock on the next cycle. A set-register write with the gate bit at 1 disables it. Neither write changes the select output.
- R9: Reads of the set and clear addresses return the committed select field and gate bit at their control-word positions, with all other bits 0. The staged copy is not returned.
- R10: A read of the status register (0x10) returns the error flag in bit 0 and the pending flag in bit 1. A read of the update register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| sel_o | output | SEL_W | Committed parent select index |
| clk_en_o | output | 1 | 1 when the muxed clock may run |
| sel_err_o | output | 1 | Sticky flag for a refused select |
| upd_pending_o | output | 1 | Staged select edited but not yet committed |

## Verification
The select path is driven three ways: by plain control-word writes, by clear/set sequences closed with an update strobe, and by set writes on an instance built without the update bit. Together these show whether each path commits, and whether it commits on the right write. Out-of-range values are sent down both the update path and the plain path. A set write that ORs into an invalid index is also sent on the direct-commit instance. These cases separate a refused commit from a silent truncation. Gate writes through set and clear, and an update write with its bit at 0, show that the select output stays unchanged when only the gate or nothing should change.

// File: rtl/cmux_pkg.sv
// Shared register offsets and decode type for the clock select register unit.
// Assumes word-aligned byte addressing on the register bus.
package cmux_pkg;

    localparam int OFS_CTRL = 0;
    localparam int OFS_SET  = 4;
    localparam int OFS_CLR  = 8;
    localparam int OFS_UPD  = 12;
    localparam int OFS_STAT = 16;

    typedef struct packed {
        logic ctrl;
        logic set;
        logic clr;
        logic upd;
        logic stat;
    } reg_hit_t;

endpackage

// File: rtl/cmux_addr_dec.sv
// Address decoder: turns a byte address into one-hot register hits.
// Assumes unmapped or misaligned addresses hit nothing.
module cmux_addr_dec
    import cmux_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_hit_t          hit
);

    // Compare the full address against each register offset.
    always_comb begin
        hit.ctrl = (addr == ADDR_W'(OFS_CTRL));
        hit.set  = (addr == ADDR_W'(OFS_SET));
        hit.clr  = (addr == ADDR_W'(OFS_CLR));
        hit.upd  = (addr == ADDR_W'(OFS_UPD));
        hit.stat = (addr == ADDR_W'(OFS_STAT));
    end

endmodule

// File: rtl/cmux_sel_core.sv
// Select state: staged copy, committed index, sticky error and pending flag.
// HAS_UPD picks commit-on-update-strobe or commit-on-set-write.
// Assumes at most one write strobe is active per cycle.
module cmux_sel_core #(
    parameter int NUM_PARENTS = 5,
    parameter int SEL_W       = 3,
    parameter bit HAS_UPD     = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_set,
    input  logic             wr_clr,
    input  logic             upd_fire,
    input  logic [SEL_W-1:0] wr_field,
    output logic [SEL_W-1:0] sel_q,
    output logic             err_q,
    output logic             pend_q
);

    localparam logic [SEL_W:0] LIMIT = (SEL_W+1)'(NUM_PARENTS);

    logic [SEL_W-1:0] staged_q;
    logic             commit_req;
    logic [SEL_W-1:0] commit_val;
    logic             commit_ok;
    logic             ctrl_ok;

    generate
        if (HAS_UPD) begin : g_upd_strobe
            assign commit_req = upd_fire;
            assign commit_val = staged_q;
        end else begin : g_set_direct
            assign commit_req = wr_set;
            assign commit_val = staged_q | wr_field;
        end
    endgenerate

    // Range checks for both commit paths.
    always_comb begin
        commit_ok = ({1'b0, commit_val} < LIMIT);
        ctrl_ok   = ({1'b0, wr_field} < LIMIT);
    end

    // Update staged copy, committed index and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= '0;
            staged_q <= '0;
            err_q    <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                if (ctrl_ok) begin
                    sel_q    <= wr_field;
                    staged_q <= wr_field;
                    pend_q   <= 1'b0;
                end else begin
                    err_q <= 1'b1;
                end
            end else if (wr_clr) begin
                staged_q <= staged_q & ~wr_field;
                pend_q   <= 1'b1;
            end else if (wr_set) begin
                staged_q <= staged_q | wr_field;
                pend_q   <= HAS_UPD;
            end
            if (commit_req) begin
                if (commit_ok) begin
                    sel_q <= commit_val;
                end else begin
                    err_q <= 1'b1;
                end
                pend_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cmux_gate_ctl.sv
// Gate-off bit: 1 holds the muxed clock off. Reset leaves the clock off.
// Assumes one write strobe per cycle.
module cmux_gate_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl,
    input  logic ctrl_gate,
    input  logic set_gate,
    input  logic clr_gate,
    output logic gate_q
);

    // Hold the gate bit; a control write loads it, set/clear force it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b1;
        end else if (wr_ctrl) begin
            gate_q <= ctrl_gate;
        end else if (set_gate) begin
            gate_q <= 1'b1;
        end else if (clr_gate) begin
            gate_q <= 1'b0;
        end
    end

endmodule

// File: rtl/cmux_sel_regs.sv
// Top of the clock select register unit: bus decode, select state, gate bit,
// stored spare bits of the control word, and the read multiplexer.
// Assumes select field, gate bit and update bit positions fit in DATA_W and
// select field and gate bit do not overlap.
module cmux_sel_regs
    import cmux_pkg::*;
#(
    parameter int NUM_PARENTS = 5,
    parameter int SEL_W       = ($clog2(NUM_PARENTS) < 1) ? 1 : $clog2(NUM_PARENTS),
    parameter int SEL_SHIFT   = 4,
    parameter int GATE_BIT    = 8,
    parameter int UPD_BIT     = 0,
    parameter bit HAS_UPD     = 1'b1,
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [SEL_W-1:0]  sel_o,
    output logic              clk_en_o,
    output logic              sel_err_o,
    output logic              upd_pending_o
);

    localparam logic [DATA_W-1:0] SEL_MASK  = {{(DATA_W-SEL_W){1'b0}}, {SEL_W{1'b1}}} << SEL_SHIFT;
    localparam logic [DATA_W-1:0] GATE_MASK = {{(DATA_W-1){1'b0}}, 1'b1} << GATE_BIT;

    reg_hit_t          hit;
    logic              wr_ctrl, wr_set, wr_clr, upd_fire;
    logic [SEL_W-1:0]  wr_field;
    logic [SEL_W-1:0]  sel_q;
    logic              gate_q, err_q, pend_q;
    logic [DATA_W-1:0] spare_q;
    logic [DATA_W-1:0] field_rd;

    cmux_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    // Qualify register hits with the write strobe and extract the field.
    always_comb begin
        wr_ctrl  = bus_we & hit.ctrl;
        wr_set   = bus_we & hit.set;
        wr_clr   = bus_we & hit.clr;
        upd_fire = bus_we & hit.upd & bus_wdata[UPD_BIT];
        wr_field = bus_wdata[SEL_SHIFT +: SEL_W];
    end

    cmux_sel_core #(
        .NUM_PARENTS (NUM_PARENTS),
        .SEL_W       (SEL_W),
        .HAS_UPD     (HAS_UPD)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .wr_set   (wr_set),
        .wr_clr   (wr_clr),
        .upd_fire (upd_fire),
        .wr_field (wr_field),
        .sel_q    (sel_q),
        .err_q    (err_q),
        .pend_q   (pend_q)
    );

    cmux_gate_ctl u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .ctrl_gate (bus_wdata[GATE_BIT]),
        .set_gate  (wr_set & bus_wdata[GATE_BIT]),
        .clr_gate  (wr_clr & bus_wdata[GATE_BIT]),
        .gate_q    (gate_q)
    );

    // Keep the control-word bits that are neither select nor gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spare_q <= '0;
        end else if (wr_ctrl) begin
            spare_q <= bus_wdata & ~(SEL_MASK | GATE_MASK);
        end
    end

    // Build the committed field view and select the read word.
    always_comb begin
        field_rd = ({{(DATA_W-SEL_W){1'b0}}, sel_q} << SEL_SHIFT)
                 | ({{(DATA_W-1){1'b0}}, gate_q} << GATE_BIT);
        bus_rdata = '0;
        if (hit.ctrl) begin
            bus_rdata = spare_q | field_rd;
        end else if (hit.set || hit.clr) begin
            bus_rdata = field_rd;
        end else if (hit.stat) begin
            bus_rdata = {{(DATA_W-2){1'b0}}, pend_q, err_q};
        end
    end

    assign sel_o         = sel_q;
    assign clk_en_o      = ~gate_q;
    assign sel_err_o     = err_q;
    assign upd_pending_o = pend_q;

endmodule

// File: rtl/cmux_sel_regs_chk.sv
// Port-level property checker for cmux_sel_regs, attached by bind.
module cmux_sel_regs_chk
    import cmux_pkg::*;
#(
    parameter int NUM_PARENTS = 5,
    parameter int SEL_W       = 3,
    parameter int GATE_BIT    = 8,
    parameter int UPD_BIT     = 0,
    parameter bit HAS_UPD     = 1'b1,
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [SEL_W-1:0]  sel_o,
    input logic              clk_en_o,
    input logic              sel_err_o,
    input logic              upd_pending_o
);

    logic set_w, clr_w, upd_w;
    assign set_w = bus_we && (bus_addr == ADDR_W'(OFS_SET));
    assign clr_w = bus_we && (bus_addr == ADDR_W'(OFS_CLR));
    assign upd_w = bus_we && (bus_addr == ADDR_W'(OFS_UPD));

    // R3
    sel_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(sel_o) < NUM_PARENTS);

    // R3
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err_o |=> sel_err_o);

    // R4
    clr_keeps_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> $stable(sel_o));

    // R5
    set_pends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_UPD && set_w) |=> (upd_pending_o && $stable(sel_o)));

    // R6
    upd_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_w && bus_wdata[UPD_BIT]) |=> !upd_pending_o);

    // R8
    set_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_w && bus_wdata[GATE_BIT]) |=> !clk_en_o);

    // R8
    clr_gate_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w && bus_wdata[GATE_BIT]) |=> clk_en_o);

    // R2
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(sel_o) && $stable(clk_en_o)));

endmodule

bind cmux_sel_regs cmux_sel_regs_chk #(
    .NUM_PARENTS (NUM_PARENTS),
    .SEL_W       (SEL_W),
    .GATE_BIT    (GATE_BIT),
    .UPD_BIT     (UPD_BIT),
    .HAS_UPD     (HAS_UPD),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .sel_o         (sel_o),
    .clk_en_o      (clk_en_o),
    .sel_err_o     (sel_err_o),
    .upd_pending_o (upd_pending_o)
);

// File: tb/tb_cmux_sel_regs.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_cmux_sel_regs;

    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] A_CTRL = 5'd0;
    localparam logic [4:0] A_SET  = 5'd4;
    localparam logic [4:0] A_CLR  = 5'd8;
    localparam logic [4:0] A_UPD  = 5'd12;
    localparam logic [4:0] A_STAT = 5'd16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata, rdata_nu;
    logic [2:0]  sel, sel_nu;
    logic        en, en_nu, err, err_nu, pend, pend_nu;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmux_sel_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata), .sel_o(sel),
        .clk_en_o(en), .sel_err_o(err), .upd_pending_o(pend)
    );

    cmux_sel_regs #(.HAS_UPD(1'b0)) dut_nu (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_nu), .sel_o(sel_nu),
        .clk_en_o(en_nu), .sel_err_o(err_nu), .upd_pending_o(pend_nu)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 sel", 32'(sel), 32'd0);
        chk("R1 clk_en", 32'(en), 32'd0);
        chk("R1 err", 32'(err), 32'd0);
        chk("R1 pending", 32'(pend), 32'd0);
    endtask

    task automatic t_plain();
        logic [31:0] d;
        wr(A_CTRL, 32'hA5A0_003B);
        chk("R2 sel", 32'(sel), 32'd3);
        chk("R2 clk_en", 32'(en), 32'd1);
        rd(A_CTRL, d);
        chk("R2 readback", d, 32'hA5A0_003B);
        wr(A_CTRL, 32'hA5A0_0120);
        chk("R2 sel2", 32'(sel), 32'd2);
        chk("R2 gated", 32'(en), 32'd0);
        rd(A_CTRL, d);
        chk("R2 readback2", d, 32'hA5A0_0120);
    endtask

    task automatic t_staged();
        logic [31:0] d;
        wr(A_CLR, 32'h70);
        chk("R4 sel kept", 32'(sel), 32'd2);
        wr(A_SET, 32'h40);
        chk("R5 sel kept", 32'(sel), 32'd2);
        chk("R5 pending", 32'(pend), 32'd1);
        rd(A_SET, d);
        chk("R9 set read", d, 32'h120);
        wr(A_UPD, 32'h2);
        chk("R6 no-bit write ignored", 32'(sel), 32'd2);
        chk("R6 still pending", 32'(pend), 32'd1);
        wr(A_UPD, 32'h1);
        chk("R6 committed", 32'(sel), 32'd4);
        chk("R6 pending cleared", 32'(pend), 32'd0);
        rd(A_STAT, d);
        chk("R10 status clean", d, 32'h0);
    endtask

    task automatic t_invalid();
        logic [31:0] d;
        wr(A_CLR, 32'h70);
        wr(A_SET, 32'h60);
        wr(A_UPD, 32'h1);
        chk("R3 upd refused", 32'(sel), 32'd4);
        chk("R3 err set", 32'(err), 32'd1);
        rd(A_STAT, d);
        chk("R10 status err", d, 32'h1);
        wr(A_CTRL, 32'h70);
        chk("R3 ctrl refused", 32'(sel), 32'd4);
        wr(A_CTRL, 32'h10);
        chk("R3 valid after err", 32'(sel), 32'd1);
        chk("R3 err sticky", 32'(err), 32'd1);
    endtask

    task automatic t_gate();
        logic [31:0] d;
        wr(A_SET, 32'h100);
        chk("R8 set gates off", 32'(en), 32'd0);
        chk("R8 sel kept", 32'(sel), 32'd1);
        wr(A_CLR, 32'h100);
        chk("R8 clr enables", 32'(en), 32'd1);
        chk("R8 sel kept2", 32'(sel), 32'd1);
        rd(A_CLR, d);
        chk("R9 clr read", d, 32'h10);
        rd(A_UPD, d);
        chk("R10 upd read zero", d, 32'h0);
        rd(A_STAT, d);
        chk("R10 status err+pend", d, 32'h3);
    endtask

    task automatic t_no_upd();
        do_reset();
        wr(A_CLR, 32'h70);
        chk("R7 clr no commit", 32'(sel_nu), 32'd0);
        wr(A_SET, 32'h30);
        chk("R7 set commits", 32'(sel_nu), 32'd3);
        chk("R7 no pending", 32'(pend_nu), 32'd0);
        wr(A_SET, 32'h40);
        chk("R7 OR to 7 refused", 32'(sel_nu), 32'd3);
        chk("R3 err on direct path", 32'(err_nu), 32'd1);
    endtask

    initial begin
        t_reset();
        t_plain();
        t_staged();
        t_invalid();
        t_gate();
        t_no_upd();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule